// File: doc/BRIEF.md
# PLL Power-Up and Retune Sequencer

This block is the digital controller that sits beside one analog PLL and its consumer clock mux. It drives the PLL's control lines in a fixed order for two jobs. A cold start powers the PLL on and waits. It then drops isolation and waits again. Next it loads the frequency word with a change strobe and turns the output on. After the settle time it releases the output divider from reset. A retune first moves the consumer onto the 26 MHz reference clock. It then turns the PLL output off, loads the new word, turns the output back on, waits the settle time and hands the consumer back to the PLL.

All waits are counted in reference-clock cycles and are set by parameters. Two further parameters shape the block for a given PLL. One says whether the PLL has a divider reset to release. The other says whether the PLL has a parking path; without one, a retune turns the output off, loads, turns it on and waits, and never touches the mux. The frequency word and the target rate are captured when a request is accepted. The target rate, in MHz, decides whether the glitch-free enable is set.

Top module: `pll_seq_ctrl`

## Requirements
- R1: The block accepts a cold start on `boot_req` when idle. On the accept edge it raises `pwr_on`. `iso_on` falls PWR_DLY+1 cycles later. The word is loaded ISO_DLY+2 cycles after that, and `pll_en` rises one cycle after the load.
- R2: A cold start ends SETTLE_DLY+1 cycles after `pll_en` rises. When HAS_DIV_RST is 1, `div_en` and `div_rst_n` both go to 1 on that final edge. When HAS_DIV_RST is 0, both stay 0.
- R3: When a word is loaded, `glitch_free` takes 0 if the captured rate is below 374 MHz and 1 otherwise. At reset it is 1.
- R4: Each load copies the word captured at accept to `freq_word`. `freq_chg` is high for exactly the one cycle in which the new word first appears. `freq_word` never changes without `freq_chg`.
- R5: With HAS_PARK = 1, a retune accepted from `tune_req` runs in this order. `mux_ref` goes to 1 on the accept edge. `pll_en` goes to 0 one cycle later. The load follows one cycle after that, and `pll_en` goes to 1 one cycle after the load. `mux_ref` returns to 0 SETTLE_DLY+1 cycles after that.
- R6: With HAS_PARK = 0, a retune runs the same steps with the same timing, but `mux_ref` stays 0.
- R7: `busy` is high from the cycle after the accept edge until the final step. Both requests are ignored while `busy` is high.
- R8: A delay parameter of 0 adds no wait cycles. A cold start with all delays 0 then keeps `busy` high for 5 cycles, and such a retune keeps it high for 4.
- R9: `done` is a one-cycle pulse on the final edge of every sequence, and it is never high together with `busy`.
- R10: When both requests arrive while idle, the cold start is taken and the retune is dropped.
- R11: Synchronous reset gives the following values: `pwr_on`=0, `iso_on`=1, `pll_en`=0, `freq_word`=0, `freq_chg`=0, `glitch_free`=1, `div_en`=0, `div_rst_n`=0, `mux_ref`=0, `busy`=0, `done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_req | input | 1 | Start a cold power-up sequence |
| tune_req | input | 1 | Start a retune sequence |
| freq_word_in | input | FREQ_W | New frequency word, captured on accept |
| rate_mhz | input | RATE_W | Target rate in MHz, captured on accept |
| pwr_on | output | 1 | PLL power switch |
| iso_on | output | 1 | PLL output isolation |
| pll_en | output | 1 | PLL output enable |
| freq_word | output | FREQ_W | Frequency word to the PLL |
| freq_chg | output | 1 | One-cycle word-change strobe |
| glitch_free | output | 1 | Glitch-free mode enable |
| div_en | output | 1 | Output divider enable |
| div_rst_n | output | 1 | Output divider reset release |
| mux_ref | output | 1 | Consumer mux on reference clock when 1 |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The bench builds two copies side by side. The first has delays of 3, 2 and 5 cycles, a divider reset and a parking path. It shows each wait separately, so a wait that ends one cycle early or late is caught. The second has all delays at 0, no divider reset and no parking path. It exercises the shortest sequences, the skipped divider step and the retune that never parks. Both copies are fed the same requests. Because they finish at different times, a request can reach one copy while it is busy and the other while it is idle.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PWR_WAIT,
    ST_ISO_WAIT,
    ST_DISABLE,
    ST_LOAD,
    ST_ENABLE,
    ST_SETTLE
  } seq_state_t;

  typedef enum logic {
    JOB_BOOT,
    JOB_TUNE
  } seq_job_t;
endpackage

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (load) cnt <= load_val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && zero) |=> zero);
endmodule

// File: rtl/pll_seq_rate_cmp.sv
module pll_seq_rate_cmp #(
  parameter int RATE_W     = 12,
  parameter int GF_MIN_MHZ = 374
) (
  input  logic [RATE_W-1:0] rate,
  output logic              fast
);
  localparam logic [RATE_W-1:0] THRESH = RATE_W'(GF_MIN_MHZ);
  assign fast = (rate >= THRESH);
endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
  import pll_seq_pkg::*;
#(
  parameter int FREQ_W      = 22,
  parameter int RATE_W      = 12,
  parameter int PWR_DLY     = 30,
  parameter int ISO_DLY     = 1,
  parameter int SETTLE_DLY  = 20,
  parameter bit HAS_DIV_RST = 1'b1,
  parameter bit HAS_PARK    = 1'b1,
  parameter int GF_MIN_MHZ  = 374
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boot_req,
  input  logic              tune_req,
  input  logic [FREQ_W-1:0] freq_word_in,
  input  logic [RATE_W-1:0] rate_mhz,
  output logic              pwr_on,
  output logic              iso_on,
  output logic              pll_en,
  output logic [FREQ_W-1:0] freq_word,
  output logic              freq_chg,
  output logic              glitch_free,
  output logic              div_en,
  output logic              div_rst_n,
  output logic              mux_ref,
  output logic              busy,
  output logic              done
);
  localparam int MAX_A = (PWR_DLY > ISO_DLY) ? PWR_DLY : ISO_DLY;
  localparam int MAX_D = (MAX_A > SETTLE_DLY) ? MAX_A : SETTLE_DLY;
  localparam int CNT_W = (MAX_D < 1) ? 1 : $clog2(MAX_D + 1);

  seq_state_t        state;
  seq_job_t          job;
  logic [FREQ_W-1:0] word_q;
  logic              fast_q;
  logic              rate_fast;
  logic              tmr_load;
  logic [CNT_W-1:0]  tmr_val;
  logic              tmr_zero;

  pll_seq_rate_cmp #(.RATE_W(RATE_W), .GF_MIN_MHZ(GF_MIN_MHZ)) u_cmp (
    .rate (rate_mhz),
    .fast (rate_fast)
  );

  pll_seq_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state)
      ST_IDLE: if (boot_req) begin
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(PWR_DLY);
      end
      ST_PWR_WAIT: if (tmr_zero) begin
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(ISO_DLY);
      end
      ST_ENABLE: begin
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(SETTLE_DLY);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      job         <= JOB_BOOT;
      word_q      <= '0;
      fast_q      <= 1'b1;
      pwr_on      <= 1'b0;
      iso_on      <= 1'b1;
      pll_en      <= 1'b0;
      freq_word   <= '0;
      freq_chg    <= 1'b0;
      glitch_free <= 1'b1;
      div_en      <= 1'b0;
      div_rst_n   <= 1'b0;
      mux_ref     <= 1'b0;
      busy        <= 1'b0;
      done        <= 1'b0;
    end else begin
      freq_chg <= 1'b0;
      done     <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (boot_req) begin
            job    <= JOB_BOOT;
            busy   <= 1'b1;
            pwr_on <= 1'b1;
            word_q <= freq_word_in;
            fast_q <= rate_fast;
            state  <= ST_PWR_WAIT;
          end else if (tune_req) begin
            job    <= JOB_TUNE;
            busy   <= 1'b1;
            word_q <= freq_word_in;
            fast_q <= rate_fast;
            if (HAS_PARK) mux_ref <= 1'b1;
            state  <= ST_DISABLE;
          end
        end
        ST_PWR_WAIT: if (tmr_zero) begin
          iso_on <= 1'b0;
          state  <= ST_ISO_WAIT;
        end
        ST_ISO_WAIT: if (tmr_zero) state <= ST_LOAD;
        ST_DISABLE: begin
          pll_en <= 1'b0;
          state  <= ST_LOAD;
        end
        ST_LOAD: begin
          freq_word   <= word_q;
          freq_chg    <= 1'b1;
          glitch_free <= fast_q;
          state       <= ST_ENABLE;
        end
        ST_ENABLE: begin
          pll_en <= 1'b1;
          state  <= ST_SETTLE;
        end
        ST_SETTLE: if (tmr_zero) begin
          if (job == JOB_BOOT && HAS_DIV_RST) begin
            div_en    <= 1'b1;
            div_rst_n <= 1'b1;
          end
          if (job == JOB_TUNE && HAS_PARK) mux_ref <= 1'b0;
          busy  <= 1'b0;
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4
  chg_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    freq_chg |=> !freq_chg);
  // R4
  word_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (freq_word != $past(freq_word)) |-> freq_chg);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R1
  iso_after_pwr_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(iso_on) |-> pwr_on);
  // R2
  div_after_en_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(div_en) |-> (pll_en && div_rst_n));
  // R5
  unpark_locked_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(mux_ref) |-> pll_en);

  generate
    if (HAS_PARK) begin : g_park_chk
      // R5
      park_first_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(pll_en) |-> mux_ref);
    end else begin : g_nopark_chk
      // R6
      never_park_chk: assert property (@(posedge clk) disable iff (rst)
        !mux_ref);
    end
  endgenerate
endmodule

// File: tb/pll_seq_ctrl_test.sv
module pll_seq_model #(
  parameter int P = 0, parameter int I = 0, parameter int S = 0,
  parameter bit RSTB = 1'b1, parameter bit PARK = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        boot,
  input  logic        tune,
  input  logic [15:0] word,
  input  logic [11:0] rate,
  output logic        e_pwr, e_iso, e_en, e_chg, e_gf, e_div, e_rstn, e_mux,
  output logic        e_busy, e_done,
  output logic [15:0] e_freq
);
  int          t;
  bit          is_tune;
  logic [15:0] w;
  bit          fast;

  always @(posedge clk) begin
    if (rst) begin
      e_pwr = 0; e_iso = 1; e_en = 0; e_chg = 0; e_gf = 1; e_div = 0;
      e_rstn = 0; e_mux = 0; e_busy = 0; e_done = 0; e_freq = 0; t = 0;
    end else begin
      e_chg = 0; e_done = 0;
      if (!e_busy) begin
        if (boot || tune) begin
          e_busy = 1; t = 0; is_tune = !boot; w = word; fast = (rate >= 374);
          if (boot) e_pwr = 1;
          else if (PARK) e_mux = 1;
        end
      end else begin
        t++;
        if (!is_tune) begin
          if (t == 1 + P) e_iso = 0;
          if (t == 3 + P + I) begin e_freq = w; e_chg = 1; e_gf = fast; end
          if (t == 4 + P + I) e_en = 1;
          if (t == 5 + P + I + S) begin
            if (RSTB) begin e_div = 1; e_rstn = 1; end
            e_busy = 0; e_done = 1;
          end
        end else begin
          if (t == 1) e_en = 0;
          if (t == 2) begin e_freq = w; e_chg = 1; e_gf = fast; end
          if (t == 3) e_en = 1;
          if (t == 4 + S) begin
            if (PARK) e_mux = 0;
            e_busy = 0; e_done = 1;
          end
        end
      end
    end
  end
endmodule

module pll_seq_ctrl_test;
  logic clk = 0;
  logic rst = 1;
  logic boot_req = 0, tune_req = 0;
  logic [15:0] word = 0;
  logic [11:0] rate = 0;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  logic a_pwr, a_iso, a_en, a_chg, a_gf, a_div, a_rstn, a_mux, a_busy, a_done;
  logic b_pwr, b_iso, b_en, b_chg, b_gf, b_div, b_rstn, b_mux, b_busy, b_done;
  logic [15:0] a_freq, b_freq;
  logic ma_pwr, ma_iso, ma_en, ma_chg, ma_gf, ma_div, ma_rstn, ma_mux, ma_busy, ma_done;
  logic mb_pwr, mb_iso, mb_en, mb_chg, mb_gf, mb_div, mb_rstn, mb_mux, mb_busy, mb_done;
  logic [15:0] ma_freq, mb_freq;

  pll_seq_ctrl #(.FREQ_W(16), .RATE_W(12), .PWR_DLY(3), .ISO_DLY(2), .SETTLE_DLY(5),
                 .HAS_DIV_RST(1'b1), .HAS_PARK(1'b1)) uut (
    .clk(clk), .rst(rst), .boot_req(boot_req), .tune_req(tune_req),
    .freq_word_in(word), .rate_mhz(rate), .pwr_on(a_pwr), .iso_on(a_iso),
    .pll_en(a_en), .freq_word(a_freq), .freq_chg(a_chg), .glitch_free(a_gf),
    .div_en(a_div), .div_rst_n(a_rstn), .mux_ref(a_mux), .busy(a_busy), .done(a_done));

  pll_seq_ctrl #(.FREQ_W(16), .RATE_W(12), .PWR_DLY(0), .ISO_DLY(0), .SETTLE_DLY(0),
                 .HAS_DIV_RST(1'b0), .HAS_PARK(1'b0)) uut_b (
    .clk(clk), .rst(rst), .boot_req(boot_req), .tune_req(tune_req),
    .freq_word_in(word), .rate_mhz(rate), .pwr_on(b_pwr), .iso_on(b_iso),
    .pll_en(b_en), .freq_word(b_freq), .freq_chg(b_chg), .glitch_free(b_gf),
    .div_en(b_div), .div_rst_n(b_rstn), .mux_ref(b_mux), .busy(b_busy), .done(b_done));

  pll_seq_model #(.P(3), .I(2), .S(5), .RSTB(1'b1), .PARK(1'b1)) mdl_a (
    .clk(clk), .rst(rst), .boot(boot_req), .tune(tune_req), .word(word), .rate(rate),
    .e_pwr(ma_pwr), .e_iso(ma_iso), .e_en(ma_en), .e_chg(ma_chg), .e_gf(ma_gf),
    .e_div(ma_div), .e_rstn(ma_rstn), .e_mux(ma_mux), .e_busy(ma_busy),
    .e_done(ma_done), .e_freq(ma_freq));

  pll_seq_model #(.P(0), .I(0), .S(0), .RSTB(1'b0), .PARK(1'b0)) mdl_b (
    .clk(clk), .rst(rst), .boot(boot_req), .tune(tune_req), .word(word), .rate(rate),
    .e_pwr(mb_pwr), .e_iso(mb_iso), .e_en(mb_en), .e_chg(mb_chg), .e_gf(mb_gf),
    .e_div(mb_div), .e_rstn(mb_rstn), .e_mux(mb_mux), .e_busy(mb_busy),
    .e_done(mb_done), .e_freq(mb_freq));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the behavioural models
  always @(negedge clk) begin
    if (!rst) begin
      chk("R1", "A pwr_on", a_pwr, ma_pwr);       chk("R1", "A iso_on", a_iso, ma_iso);
      chk("R1", "A pll_en", a_en, ma_en);         chk("R4", "A freq_word", a_freq, ma_freq);
      chk("R4", "A freq_chg", a_chg, ma_chg);     chk("R3", "A glitch_free", a_gf, ma_gf);
      chk("R2", "A div_en", a_div, ma_div);       chk("R2", "A div_rst_n", a_rstn, ma_rstn);
      chk("R5", "A mux_ref", a_mux, ma_mux);      chk("R7", "A busy", a_busy, ma_busy);
      chk("R9", "A done", a_done, ma_done);
      chk("R8", "B pwr_on", b_pwr, mb_pwr);       chk("R8", "B iso_on", b_iso, mb_iso);
      chk("R8", "B pll_en", b_en, mb_en);         chk("R4", "B freq_word", b_freq, mb_freq);
      chk("R4", "B freq_chg", b_chg, mb_chg);     chk("R3", "B glitch_free", b_gf, mb_gf);
      chk("R2", "B div_en", b_div, mb_div);       chk("R2", "B div_rst_n", b_rstn, mb_rstn);
      chk("R6", "B mux_ref", b_mux, mb_mux);      chk("R7", "B busy", b_busy, mb_busy);
      chk("R9", "B done", b_done, mb_done);
    end
  end

  int a_run = 0, b_run = 0, a_last = 0, b_last = 0;
  always @(negedge clk) begin
    if (a_busy) a_run++;
    if (a_done) begin a_last = a_run; a_run = 0; end
    if (b_busy) b_run++;
    if (b_done) begin b_last = b_run; b_run = 0; end
  end

  task automatic req(input bit b, input bit t, input logic [15:0] w, input logic [11:0] r);
    @(negedge clk);
    boot_req = b; tune_req = t; word = w; rate = r;
    @(negedge clk);
    boot_req = 0; tune_req = 0;
  endtask

  task automatic settle();
    repeat (25) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    // R11 reset values at the ports
    chk("R11", "reset pwr_on", a_pwr, 0);
    chk("R11", "reset iso_on", a_iso, 1);
    chk("R11", "reset glitch_free", a_gf, 1);
    chk("R11", "reset busy", a_busy, 0);
    chk("R11", "reset freq_word", a_freq, 0);

    // R1 R3: cold start below threshold; R7: requests during busy ignored
    req(1, 0, 16'h1234, 12'd300);
    req(1, 0, 16'h5555, 12'd500);
    req(0, 1, 16'h6666, 12'd500);
    settle();
    chk("R3", "A glitch_free after 300 MHz", a_gf, 0);
    chk("R7", "A word kept while busy", a_freq, 16'h1234);
    chk("R2", "A divider released", a_div, 1);
    chk("R2", "B divider not configured", b_div, 0);
    chk("R1", "A cold busy length", a_last, 15);

    // R5 R6: retune at 374 MHz boundary
    req(0, 1, 16'hBEEF, 12'd374);
    @(negedge clk);
    chk("R5", "A parked during retune", a_mux, 1);
    chk("R6", "B never parks", b_mux, 0);
    settle();
    chk("R3", "A glitch_free at 374 MHz", a_gf, 1);
    chk("R5", "A returned to PLL", a_mux, 0);
    chk("R5", "A retune busy length", a_last, 9);
    chk("R8", "B retune busy length", b_last, 4);

    // R10: both requests together -> cold start
    req(1, 1, 16'h0F0F, 12'd373);
    chk("R10", "A not parked on tie", a_mux, 0);
    chk("R10", "A power path taken", a_pwr, 1);
    settle();
    chk("R3", "A glitch_free at 373 MHz", a_gf, 0);
    chk("R8", "B cold busy length", b_last, 5);
    chk("R9", "A done low at rest", a_done, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule